// File: doc/BRIEF.md
# Token-Passed Pixel Row Readout

This block moves the per-pixel acquisition words of a pixel array onto a single output bus without any column-select decoding. The pixels of one row hang on a shared row bus. A readout token travels along the row: the pixel that holds it drives the bus, one word per row-clock period. After its last word it releases the bus and hands the token to its neighbour. How many words a pixel sends (four, two or one) depends on a three-bit mode that is sampled at the start of each frame.

The rows share the block output through a circulating one-hot row selector that moves one row per master clock. A row's pixels step forward only at the moment the selector leaves that row, so each row effectively runs on a clock at 1/NUM_ROWS of the master rate. The bus word it presents has the rest of the rotation to settle before the row is selected again. A single-cycle frame pulse copies the incoming pixel data into per-pixel shadow registers, latches the mode, re-arms every pixel and sends the selector back to row 0, all on the same edge.

Top module: `readout_chain`

## Requirements
- R1: After reset and before any frame, `out_valid` is 0, every bit of `row_done` is 1 and `row_sel` equals 1 (row 0 selected).
- R2: `row_sel` always has exactly one bit set. It moves from bit r to bit r+1 on each master clock, wrapping from the last row to row 0, and the cycle after a frame pulse it is back at row 0.
- R3: A row's pixels advance only on the master edge where the selection leaves that row. Counting the cycle right after the frame edge as cycle 0, word k of row r's stream appears on `out_word` with `out_valid` high in cycle r + NUM_ROWS*k, and in every cycle until all rows are drained.
- R4: Within a row, pixels are read in index order 0 to PIX_PER_ROW-1. A pixel drives the row bus only while it holds the token, and it passes the token on only after its own last word, so at most one pixel drives a row bus at a time.
- R5: The number of words per pixel is set by `mode`: 0 and 4 give 4 words; 1 gives 2; 2, 3 and 5 give 1; the unused codes 6 and 7 give 4.
- R6: In every mode except 3, a pixel sends its slots in order from slot 0 upward. Slot s of pixel p in row r is `pix_data[((r*PIX_PER_ROW+p)*4+s)*WORD_W +: WORD_W]`.
- R7: In mode 3 a pixel sends a single word that packs the low CNT_W bits of each slot, with slot s at bits [s*CNT_W +: CNT_W]. The remaining upper bits are zero.
- R8: `row_done[r]` goes high in the cycle after row r's last pixel sent its final word, and stays high until the next frame. While the selected row is done, `out_valid` is 0.
- R9: `pix_data` and `mode` are sampled only on the frame edge. Changing them during a readout has no effect on the words of that readout.
- R10: A frame pulse in the middle of a readout abandons it and starts the new readout from row 0, pixel 0, slot 0. It takes priority over the row advance that falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master readout clock |
| rst | input | 1 | Synchronous active-high reset |
| frame | input | 1 | One-cycle frame pulse: latch data and mode, restart readout |
| mode | input | 3 | Readout mode code, sampled at frame |
| pix_data | input | NUM_ROWS*PIX_PER_ROW*4*WORD_W | Slot words of all pixels, captured at frame |
| out_valid | output | 1 | A pixel of the selected row is driving a word |
| out_word | output | WORD_W | Word of the selected row, zero when not valid |
| row_sel | output | NUM_ROWS | One-hot row buffer enable |
| row_done | output | NUM_ROWS | Per-row flag: last pixel has passed the token |

## Verification
The row selector never stops rotating, so a frame pulse always lands on the same edge as some row's advance tick. The bench raises a frame partway through a full-mode readout. It then expects the very next cycle to show row 0, pixel 0, slot 0 of the new data in the new mode, with no word of the abandoned stream. A second collision is also provoked: the data and mode inputs are changed mid-readout while the pixels keep stepping, and the stream is judged against the values captured at the frame edge.

// File: rtl/ro_pkg.sv
package ro_pkg;

    localparam int SLOTS = 4;
    localparam int IDX_W = $clog2(SLOTS);

    typedef enum logic [2:0] {
        M_FULL       = 3'd0,
        M_FIRST      = 3'd1,
        M_FIRST_FAST = 3'd2,
        M_COUNT      = 3'd3,
        M_COINC      = 3'd4,
        M_COINC_FAST = 3'd5,
        M_RSVD6      = 3'd6,
        M_RSVD7      = 3'd7
    } rd_mode_t;

    typedef enum logic {
        PX_ARMED = 1'b0,
        PX_DONE  = 1'b1
    } px_state_t;

    // number of words one pixel places on the row bus
    function automatic logic [2:0] words_for(rd_mode_t m);
        case (m)
            M_FIRST:                             return 3'd2;
            M_FIRST_FAST, M_COUNT, M_COINC_FAST: return 3'd1;
            default:                             return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/ro_pixel.sv
module ro_pixel
    import ro_pkg::*;
#(
    parameter int WORD_W = 23,
    parameter int CNT_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame,
    input  logic                    tick,
    input  logic                    tok_in,
    input  rd_mode_t                mode,
    input  logic [SLOTS*WORD_W-1:0] data_in,
    output logic                    drive,
    output logic [WORD_W-1:0]       word,
    output logic                    tok_out
);

    px_state_t               st;
    logic [IDX_W-1:0]        idx;
    logic [SLOTS*WORD_W-1:0] shadow;
    logic [2:0]              last;
    logic [WORD_W-1:0]       cnt_word;

    assign last    = words_for(mode) - 3'd1;
    assign drive   = tok_in && (st == PX_ARMED);
    assign tok_out = (st == PX_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PX_DONE;
            idx    <= '0;
            shadow <= '0;
        end else if (frame) begin
            st     <= PX_ARMED;
            idx    <= '0;
            shadow <= data_in;
        end else if (tick && drive) begin
            if ({1'b0, idx} == last) st <= PX_DONE;
            else                     idx <= idx + 1'b1;
        end
    end

    always_comb begin
        cnt_word = '0;
        for (int s = 0; s < SLOTS; s++)
            cnt_word[s*CNT_W +: CNT_W] = shadow[s*WORD_W +: CNT_W];
    end

    always_comb begin
        if (mode == M_COUNT) word = cnt_word;
        else                 word = shadow[int'(idx)*WORD_W +: WORD_W];
    end

    // R10: a frame re-arms the pixel at its first slot
    assert_frame_rearm_R10: assert property (@(posedge clk) disable iff (rst)
        frame |=> (st == PX_ARMED) && (idx == '0));

    // R8: a finished pixel stays finished until the next frame
    assert_done_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (st == PX_DONE) && !frame |=> (st == PX_DONE));

    // R5: the slot index never passes the mode's last word
    assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        (st == PX_ARMED) |-> ({1'b0, idx} <= last));

    // R3: without its row tick the pixel does not move
    assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (rst)
        !tick && !frame |=> $stable(st) && $stable(idx));

    // R9: captured data is frozen between frames
    assert_shadow_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        !frame |=> $stable(shadow));

endmodule

// File: rtl/ro_row.sv
module ro_row
    import ro_pkg::*;
#(
    parameter int PIX_PER_ROW = 4,
    parameter int WORD_W      = 23,
    parameter int CNT_W       = 5
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                frame,
    input  logic                                tick,
    input  rd_mode_t                            mode,
    input  logic [PIX_PER_ROW*SLOTS*WORD_W-1:0] data_in,
    output logic                                row_valid,
    output logic [WORD_W-1:0]                   row_word,
    output logic                                row_done
);

    localparam int PIX_BITS = SLOTS * WORD_W;

    logic [PIX_PER_ROW:0]   tok;
    logic [PIX_PER_ROW-1:0] drive;
    logic [WORD_W-1:0]      word [PIX_PER_ROW];

    assign tok[0] = 1'b1;

    for (genvar p = 0; p < PIX_PER_ROW; p++) begin : g_pix
        ro_pixel #(
            .WORD_W (WORD_W),
            .CNT_W  (CNT_W)
        ) i_pixel (
            .clk     (clk),
            .rst     (rst),
            .frame   (frame),
            .tick    (tick),
            .tok_in  (tok[p]),
            .mode    (mode),
            .data_in (data_in[p*PIX_BITS +: PIX_BITS]),
            .drive   (drive[p]),
            .word    (word[p]),
            .tok_out (tok[p+1])
        );

        if (p > 0) begin : g_order
            // R4: a pixel cannot finish before the one ahead of it
            assert_token_order_R4: assert property (@(posedge clk) disable iff (rst)
                tok[p+1] |-> tok[p]);
        end
    end

    // bus enable model of the shared row bus
    always_comb begin
        row_word = '0;
        for (int p = 0; p < PIX_PER_ROW; p++)
            if (drive[p]) row_word = row_word | word[p];
    end

    assign row_valid = |drive;
    assign row_done  = tok[PIX_PER_ROW];

    // R4: never two drivers on one row bus
    assert_single_driver_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive));

    // R8: a finished row leaves its bus released
    assert_done_row_silent_R8: assert property (@(posedge clk) disable iff (rst)
        row_done |-> (drive == '0));

endmodule

// File: rtl/ro_ring.sv
module ro_ring #(
    parameter int NUM_ROWS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame,
    output logic [NUM_ROWS-1:0] sel,
    output logic [NUM_ROWS-1:0] tick
);

    localparam logic [NUM_ROWS-1:0] HOME = NUM_ROWS'(1);

    logic [NUM_ROWS-1:0] nxt;

    if (NUM_ROWS > 1) begin : g_rot
        assign nxt = {sel[NUM_ROWS-2:0], sel[NUM_ROWS-1]};
    end else begin : g_single
        assign nxt = sel;
    end

    always_ff @(posedge clk) begin
        if (rst || frame) sel <= HOME;
        else              sel <= nxt;
    end

    // a row steps its pixels on the edge where the enable leaves it
    assign tick = frame ? '0 : sel;

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(sel) == 1);

    assert_frame_home_R2: assert property (@(posedge clk) disable iff (rst)
        frame |=> sel[0]);

    assert_one_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tick));

endmodule

// File: rtl/readout_chain.sv
module readout_chain
    import ro_pkg::*;
#(
    parameter int NUM_ROWS    = 16,
    parameter int PIX_PER_ROW = 4,
    parameter int WORD_W      = 23,
    parameter int CNT_W       = 5
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         frame,
    input  logic [2:0]                                   mode,
    input  logic [NUM_ROWS*PIX_PER_ROW*SLOTS*WORD_W-1:0] pix_data,
    output logic                                         out_valid,
    output logic [WORD_W-1:0]                            out_word,
    output logic [NUM_ROWS-1:0]                          row_sel,
    output logic [NUM_ROWS-1:0]                          row_done
);

    localparam int ROW_BITS = PIX_PER_ROW * SLOTS * WORD_W;

    rd_mode_t            mode_q;
    logic [NUM_ROWS-1:0] row_tick;
    logic [NUM_ROWS-1:0] row_valid;
    logic [WORD_W-1:0]   row_word [NUM_ROWS];

    always_ff @(posedge clk) begin
        if (rst)        mode_q <= M_FULL;
        else if (frame) mode_q <= rd_mode_t'(mode);
    end

    ro_ring #(
        .NUM_ROWS (NUM_ROWS)
    ) i_ring (
        .clk   (clk),
        .rst   (rst),
        .frame (frame),
        .sel   (row_sel),
        .tick  (row_tick)
    );

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        ro_row #(
            .PIX_PER_ROW (PIX_PER_ROW),
            .WORD_W      (WORD_W),
            .CNT_W       (CNT_W)
        ) i_row (
            .clk       (clk),
            .rst       (rst),
            .frame     (frame),
            .tick      (row_tick[r]),
            .mode      (mode_q),
            .data_in   (pix_data[r*ROW_BITS +: ROW_BITS]),
            .row_valid (row_valid[r]),
            .row_word  (row_word[r]),
            .row_done  (row_done[r])
        );
    end

    // row output buffers onto the block bus
    always_comb begin
        out_valid = 1'b0;
        out_word  = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (row_sel[r] && row_valid[r]) begin
                out_valid = 1'b1;
                out_word  = row_word[r];
            end
        end
    end

    // R9: the latched mode only changes on a frame
    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        !frame |=> $stable(mode_q));

    // R8: a drained selected row produces no word
    assert_out_quiet_when_done_R8: assert property (@(posedge clk) disable iff (rst)
        ((row_sel & row_done) != '0) |-> !out_valid);

endmodule

// File: tb/test_readout_chain.sv
`timescale 1ns/1ps
module test_readout_chain;

    localparam int R  = 16;
    localparam int P  = 4;
    localparam int W  = 23;
    localparam int CW = 5;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               frame = 1'b0;
    logic [2:0]         mode = 3'd0;
    logic [R*P*4*W-1:0] pix_data = '0;
    logic               out_valid;
    logic [W-1:0]       out_word;
    logic [R-1:0]       row_sel;
    logic [R-1:0]       row_done;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    string cur_tag = "R3";

    logic [W-1:0] bd [R][P][4];
    logic [W-1:0] expq [$];

    always #2.5 clk = ~clk;

    readout_chain #(
        .NUM_ROWS    (R),
        .PIX_PER_ROW (P),
        .WORD_W      (W),
        .CNT_W       (CW)
    ) i_readout_chain (
        .clk       (clk),
        .rst       (rst),
        .frame     (frame),
        .mode      (mode),
        .pix_data  (pix_data),
        .out_valid (out_valid),
        .out_word  (out_word),
        .row_sel   (row_sel),
        .row_done  (row_done)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int nwords(logic [2:0] m);
        case (m)
            3'd1:             return 2;
            3'd2, 3'd3, 3'd5: return 1;
            default:          return 4;
        endcase
    endfunction

    function automatic logic [W-1:0] expw(int r, int p, int w, logic [2:0] m);
        logic [W-1:0] v;
        if (m == 3'd3) begin
            v = '0;
            for (int s = 0; s < 4; s++) v[s*CW +: CW] = bd[r][p][s][CW-1:0];
            return v;
        end
        return bd[r][p][w];
    endfunction

    // driver: load data, push the expected stream, pulse frame
    task automatic start_frame(logic [2:0] m, int seed, string tag);
        @(posedge clk);
        #1;
        for (int r = 0; r < R; r++)
            for (int p = 0; p < P; p++)
                for (int s = 0; s < 4; s++) begin
                    bd[r][p][s] = W'((seed * 40503 + r * 2654 + p * 977 + s * 131) ^ (seed << 9));
                    pix_data[((r*P+p)*4+s)*W +: W] = bd[r][p][s];
                end
        mode = m;
        expq.delete();
        for (int k = 0; k < P * nwords(m); k++)
            for (int r = 0; r < R; r++)
                expq.push_back(expw(r, k / nwords(m), k % nwords(m), m));
        cur_tag = tag;
        frame = 1'b1;
        @(posedge clk);
        #1;
        frame = 1'b0;
    endtask

    // monitor: pop and compare every produced word
    always @(negedge clk) begin
        if (mon_on && !rst && !frame) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, {cur_tag, " unexpected word"}, 32'(out_word), 32'h0);
                end else begin
                    logic [W-1:0] e;
                    e = expq.pop_front();
                    chk(out_word == e, {cur_tag, " word"}, 32'(out_word), 32'(e));
                end
            end else if (expq.size() != 0) begin
                chk(1'b0, {cur_tag, " gap in stream"}, 32'(out_valid), 32'h1);
            end
        end
    end

    // follow one readout: selector (R2), row-done timing (R8), drain
    task automatic watch(logic [2:0] m, bit disturb);
        int total = R * P * nwords(m);
        int d0    = R * (P * nwords(m) - 1) + 1;
        for (int k = 0; k < total + 2; k++) begin
            @(negedge clk);
            if (k < R + 2)
                chk(row_sel == R'(1) << (k % R), "R2 row_sel", 32'(row_sel), 32'(R'(1) << (k % R)));
            if (k == 0)
                chk(row_done == '0, "R8 row_done cleared", 32'(row_done), 32'h0);
            if (k == d0 - 1)
                chk(row_done[0] == 1'b0, "R8 row0 still busy", 32'(row_done[0]), 32'h0);
            if (k == d0) begin
                chk(row_done[0] == 1'b1, "R8 row0 done", 32'(row_done[0]), 32'h1);
                chk(row_done[R-1] == 1'b0, "R8 last row busy", 32'(row_done[R-1]), 32'h0);
            end
            if (disturb && k == 10) begin
                mode = 3'd3;
                pix_data = ~pix_data;
            end
        end
        chk(expq.size() == 0, "R3 stream drained", 32'(expq.size()), 32'h0);
        chk(out_valid == 1'b0, "R8 quiet after drain", 32'(out_valid), 32'h0);
        chk(row_done == '1, "R8 all rows done", 32'(row_done), 32'hffff);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'h0);
        chk(row_done == '1, "R1 row_done", 32'(row_done), 32'hffff);
        chk(row_sel == R'(1), "R1 row_sel", 32'(row_sel), 32'h1);
        mon_on = 1'b1;

        start_frame(3'd0, 1, "R3 R4 R6 full");
        watch(3'd0, 1'b0);
        start_frame(3'd1, 2, "R5 R6 first-event");
        watch(3'd1, 1'b0);
        start_frame(3'd2, 3, "R5 first-fast");
        watch(3'd2, 1'b0);
        start_frame(3'd3, 4, "R7 count-only");
        watch(3'd3, 1'b0);
        start_frame(3'd4, 5, "R5 R6 coinc");
        watch(3'd4, 1'b0);
        start_frame(3'd5, 6, "R5 coinc-fast");
        watch(3'd5, 1'b0);
        start_frame(3'd7, 7, "R5 reserved");
        watch(3'd7, 1'b0);

        start_frame(3'd0, 8, "R9 inputs changed");
        watch(3'd0, 1'b1);

        start_frame(3'd0, 9, "R10 abandoned");
        repeat (37) @(negedge clk);
        start_frame(3'd1, 10, "R10 restart");
        watch(3'd1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule